// File: doc/BRIEF.md
# Limited-Write Wiper Memory Controller

This block manages the saved setting of a 10-bit digital wiper. The nonvolatile store behind it can be programmed a fixed number of times (20 slots by default), and each slot, once programmed, can never change again. The controller holds the live wiper register. It applies wiper writes from the serial command decoder without limit. A store command burns the current wiper value into the next free slot. A memory-read command returns the content of any slot. Once every slot is used, the controller turns stores away.

The wiper register is reloaded from the newest programmed slot, or from midscale 0x200 when nothing has been stored yet. This happens at power-up, on the rising edge of the hardware reset pin, and on a software reset command. Every operation holds `busy` high for its own window, and that window lasts milliseconds for fuse work. All windows are parameters counted in clock cycles, so a bench can shorten them. While `busy` is high, new commands are dropped. The fuse cells are modelled as a register array that the synchronous reset clears, which represents a factory-fresh part.

Top module: `wiper_nvm_ctrl`

## Requirements
- R1: While `rst` is high, `busy` is 1, `wiper` is 0x200 and `rd_valid` is 0. After `rst` falls, `busy` stays high for exactly T_PWRUP_CYC cycles, counted from the cycle in which `rst` is first low. After that the wiper holds the restored value, which is 0x200 with no slot programmed.
- R2: A wiper write (`cmd_wr` with `cmd_data`) keeps `busy` high for T_WRITE_CYC cycles. When `busy` drops, `wiper` equals `cmd_data`.
- R3: A store issued while fewer than SLOTS slots are used keeps `busy` high for T_STORE_CYC cycles. It then programs the current wiper value into slot N, where N is the number of slots already used (slot 0 first).
- R4: A store issued when all SLOTS slots are used is rejected. `busy` is high for T_REJECT_CYC cycles and no slot changes.
- R5: A refresh keeps `busy` high for T_RESET_CYC cycles. A refresh is started by `cmd_sw_reset` or by a rising edge on `hw_reset_pin`. At its end `wiper` holds the highest-numbered programmed slot, or 0x200 when no slot is programmed.
- R6: `hw_reset_pin` acts only on its 0-to-1 transition, seen through a 2-flop synchroniser. Holding it high starts no further refresh.
- R7: A memory read (`cmd_mem_read`) takes its slot index from the low clog2(SLOTS) bits of `cmd_data` (bits 4:0 by default) and keeps `busy` high for T_READ_CYC cycles. When `busy` drops, `rd_valid` pulses for one cycle and `rd_data` holds the slot content. An unprogrammed or out-of-range slot reads 0. `rd_data` then holds its value until the next read.
- R8: Any command strobe or reset edge that arrives while `busy` is high is ignored.
- R9: Strobes arriving in the same idle cycle are resolved by fixed priority: software reset, then hardware reset edge, then store, then memory read, then wiper write. Only the winner executes.
- R10: A programmed slot never changes again, and the count of used slots only ever increases by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| hw_reset_pin | input | 1 | Asynchronous hardware reset pin, rising edge starts a refresh |
| cmd_sw_reset | input | 1 | Software reset strobe |
| cmd_wr | input | 1 | Wiper write strobe |
| cmd_store | input | 1 | Store-to-memory strobe |
| cmd_mem_read | input | 1 | Memory read strobe |
| cmd_data | input | 10 | Wiper value for writes, slot index for reads |
| wiper | output | 10 | Live wiper register |
| busy | output | 1 | Operation in progress, commands ignored |
| rd_data | output | 10 | Last memory read result |
| rd_valid | output | 1 | One-cycle pulse when a memory read completes |

## Verification
Several rules are checked by assertions on every cycle:
- the slot count stays within bounds and moves only upward one step at a time;
- a programmed slot never changes;
- a full memory never sees a programming pulse;
- no command is accepted while busy;
- the wiper and the read result change only as a busy window closes;
- a synchronised reset edge lasts one cycle.

Other behaviours can only be shown by the bench's scenarios, because they involve durations and values:
- the exact length of each busy window;
- which value a refresh restores;
- that a held reset pin does not retrigger;
- which strobe wins a same-cycle collision;
- that stores stop once the last slot is used.

// File: rtl/wnv_pkg.sv
package wnv_pkg;

    localparam int WIPER_W = 10;
    localparam logic [WIPER_W-1:0] WIPER_MID = WIPER_W'(1) << (WIPER_W - 1);

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_REFRESH = 3'd1,
        OP_WRITE   = 3'd2,
        OP_STORE   = 3'd3,
        OP_REJECT  = 3'd4,
        OP_READ    = 3'd5
    } op_e;

    typedef struct packed {
        op_e                op;
        logic [WIPER_W-1:0] data;
    } req_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/wnv_rise_detect.sv
module wnv_rise_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], pin};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R6

endmodule

// File: rtl/wnv_busy_timer.sv
module wnv_busy_timer #(
    parameter int TW      = 8,
    parameter int RST_CNT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [TW-1:0] load,
    output logic          busy,
    output logic          done
);
    logic [TW-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b1;
            cnt  <= TW'(RST_CNT);
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= load;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !busy); // R8

endmodule

// File: rtl/wnv_fuse_bank.sv
module wnv_fuse_bank
    import wnv_pkg::*;
#(
    parameter int SLOTS = 20,
    parameter int IDX_W = 5,
    parameter int CW    = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               prog_en,
    input  logic [WIPER_W-1:0] prog_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               full,
    output logic [WIPER_W-1:0] last_val,
    output logic [WIPER_W-1:0] rd_val
);
    logic [WIPER_W-1:0] cells [SLOTS];
    logic [CW-1:0]      used_q;

    assign full = (used_q == CW'(SLOTS));

    always_ff @(posedge clk) begin
        if (rst)                  used_q <= '0;
        else if (prog_en && !full) used_q <= used_q + 1'b1;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= '0;
            else if (prog_en && (used_q == CW'(g)))
                cells[g] <= prog_data;
        end

        AST_SLOT_FROZEN: assert property (@(posedge clk) disable iff (rst)
            (used_q > CW'(g)) |=> $stable(cells[g])); // R10
    end

    always_comb begin
        last_val = WIPER_MID;
        for (int i = 0; i < SLOTS; i++)
            if (CW'(i) < used_q) last_val = cells[i];
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < SLOTS; i++)
            if (rd_idx == IDX_W'(i)) rd_val = cells[i];
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        used_q <= CW'(SLOTS)); // R4
    AST_FULL_NO_PROG: assert property (@(posedge clk) disable iff (rst)
        full |-> !prog_en); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(used_q) |-> (used_q == $past(used_q) + 1'b1)); // R10

endmodule

// File: rtl/wnv_cmd_arbiter.sv
module wnv_cmd_arbiter
    import wnv_pkg::*;
(
    input  logic               busy,
    input  logic               full,
    input  logic               sw_reset,
    input  logic               hw_rise,
    input  logic               store,
    input  logic               mem_read,
    input  logic               wr,
    input  logic [WIPER_W-1:0] data,
    output logic               accept,
    output req_t               req
);
    always_comb begin
        req.op   = OP_NONE;
        req.data = data;
        if (!busy) begin
            if (sw_reset || hw_rise) req.op = OP_REFRESH;
            else if (store)          req.op = full ? OP_REJECT : OP_STORE;
            else if (mem_read)       req.op = OP_READ;
            else if (wr)             req.op = OP_WRITE;
        end
        accept = (req.op != OP_NONE);
    end

endmodule

// File: rtl/wiper_nvm_ctrl.sv
module wiper_nvm_ctrl
    import wnv_pkg::*;
#(
    parameter int SLOTS        = 20,
    parameter int T_PWRUP_CYC  = 200000,
    parameter int T_RESET_CYC  = 150000,
    parameter int T_STORE_CYC  = 800000,
    parameter int T_READ_CYC   = 130000,
    parameter int T_WRITE_CYC  = 41,
    parameter int T_REJECT_CYC = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hw_reset_pin,
    input  logic               cmd_sw_reset,
    input  logic               cmd_wr,
    input  logic               cmd_store,
    input  logic               cmd_mem_read,
    input  logic [WIPER_W-1:0] cmd_data,
    output logic [WIPER_W-1:0] wiper,
    output logic               busy,
    output logic [WIPER_W-1:0] rd_data,
    output logic               rd_valid
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CW    = $clog2(SLOTS + 1);
    localparam int MAXD  = max_of4(max_of4(T_PWRUP_CYC, T_RESET_CYC, T_STORE_CYC, T_READ_CYC),
                                   T_WRITE_CYC, T_REJECT_CYC, 1);
    localparam int TW    = $clog2(MAXD + 1);

    logic               hw_rise, accept, done, full;
    req_t               req;
    op_e                cur_op;
    logic [WIPER_W-1:0] cur_data, last_val, rd_val;
    logic [TW-1:0]      dur;

    wnv_rise_detect #(.STAGES(2)) u_rise (
        .clk(clk), .rst(rst), .pin(hw_reset_pin), .rise(hw_rise)
    );

    wnv_cmd_arbiter u_arb (
        .busy(busy), .full(full), .sw_reset(cmd_sw_reset), .hw_rise(hw_rise),
        .store(cmd_store), .mem_read(cmd_mem_read), .wr(cmd_wr),
        .data(cmd_data), .accept(accept), .req(req)
    );

    always_comb begin
        case (req.op)
            OP_REFRESH: dur = TW'(T_RESET_CYC - 1);
            OP_STORE:   dur = TW'(T_STORE_CYC - 1);
            OP_REJECT:  dur = TW'(T_REJECT_CYC - 1);
            OP_READ:    dur = TW'(T_READ_CYC - 1);
            OP_WRITE:   dur = TW'(T_WRITE_CYC - 1);
            default:    dur = '0;
        endcase
    end

    wnv_busy_timer #(.TW(TW), .RST_CNT(T_PWRUP_CYC - 1)) u_timer (
        .clk(clk), .rst(rst), .start(accept), .load(dur), .busy(busy), .done(done)
    );

    wnv_fuse_bank #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CW(CW)) u_bank (
        .clk(clk), .rst(rst),
        .prog_en(done && (cur_op == OP_STORE)), .prog_data(wiper),
        .rd_idx(cur_data[IDX_W-1:0]),
        .full(full), .last_val(last_val), .rd_val(rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_op   <= OP_REFRESH;
            cur_data <= '0;
            wiper    <= WIPER_MID;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (accept) begin
                cur_op   <= req.op;
                cur_data <= req.data;
            end else if (done) begin
                case (cur_op)
                    OP_REFRESH: wiper <= last_val;
                    OP_WRITE:   wiper <= cur_data;
                    OP_READ: begin
                        rd_data  <= rd_val;
                        rd_valid <= 1'b1;
                    end
                    default: ;
                endcase
                cur_op <= OP_NONE;
            end
        end
    end

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !accept); // R8
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy); // R9
    AST_WIPER_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(wiper) |-> ($past(busy) && !busy)); // R5
    AST_RDV_AT_END: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(busy) && !busy)); // R7

endmodule

// File: tb/tb_wiper_nvm_ctrl.sv
module tb_wiper_nvm_ctrl;
    import wnv_pkg::*;

    localparam int SLOTS = 20;
    localparam int TPU = 40, TRS = 30, TST = 50, TRD = 20, TWR = 3, TRJ = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, hw_pin, c_sw, c_wr, c_st, c_rd;
    logic [WIPER_W-1:0] c_data, wiper, rd_data;
    logic busy, rd_valid;

    wiper_nvm_ctrl #(
        .SLOTS(SLOTS), .T_PWRUP_CYC(TPU), .T_RESET_CYC(TRS), .T_STORE_CYC(TST),
        .T_READ_CYC(TRD), .T_WRITE_CYC(TWR), .T_REJECT_CYC(TRJ)
    ) dut (
        .clk(clk), .rst(rst), .hw_reset_pin(hw_pin), .cmd_sw_reset(c_sw),
        .cmd_wr(c_wr), .cmd_store(c_st), .cmd_mem_read(c_rd), .cmd_data(c_data),
        .wiper(wiper), .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    logic [WIPER_W-1:0] m_mem [SLOTS];
    int m_cnt = 0;
    logic [WIPER_W-1:0] m_wiper;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [WIPER_W-1:0] exp_refresh();
        return (m_cnt == 0) ? WIPER_MID : m_mem[m_cnt-1];
    endfunction

    function automatic logic [WIPER_W-1:0] exp_read(input int slot);
        return (slot < m_cnt) ? m_mem[slot] : '0;
    endfunction

    task automatic measure(output int len);
        len = 0;
        for (int i = 0; i < 8 && !busy; i++) @(negedge clk);
        while (busy && len < 2000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic strobe(input int kind, input logic [WIPER_W-1:0] d);
        c_data = d;
        c_sw = (kind == 0); c_st = (kind == 1); c_rd = (kind == 2); c_wr = (kind == 3);
        @(negedge clk);
        c_sw = 0; c_st = 0; c_rd = 0; c_wr = 0;
    endtask

    task automatic do_write(input logic [WIPER_W-1:0] d);
        int len;
        strobe(3, d); measure(len);
        m_wiper = d;
        chk("R2 busy length", len, TWR);
        chk("R2 wiper value", wiper, m_wiper);
    endtask

    task automatic do_store();
        int len;
        strobe(1, '0); measure(len);
        if (m_cnt < SLOTS) begin
            m_mem[m_cnt] = m_wiper; m_cnt++;
            chk("R3 store busy length", len, TST);
        end else begin
            chk("R4 reject busy length", len, TRJ);
        end
    endtask

    task automatic do_read(input int slot);
        int len;
        strobe(2, WIPER_W'(slot)); measure(len);
        chk("R7 read busy length", len, TRD);
        chk("R7 rd_valid pulse", rd_valid, 1);
        chk("R7 rd_data", rd_data, exp_read(slot));
        @(negedge clk);
        chk("R7 rd_valid one cycle", rd_valid, 0);
    endtask

    task automatic do_sw_reset();
        int len;
        strobe(0, '0); measure(len);
        m_wiper = exp_refresh();
        chk("R5 sw refresh busy length", len, TRS);
        chk("R5 sw refresh wiper", wiper, m_wiper);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int len;
        logic [WIPER_W-1:0] held;
        void'($urandom(32'd2024));
        rst = 1; hw_pin = 0; c_sw = 0; c_wr = 0; c_st = 0; c_rd = 0; c_data = '0;
        repeat (4) @(negedge clk);
        chk("R1 reset busy", busy, 1);
        chk("R1 reset wiper", wiper, WIPER_MID);
        chk("R1 reset rd_valid", rd_valid, 0);
        rst = 0;
        measure(len);
        chk("R1 power-up busy length", len, TPU);
        m_wiper = WIPER_MID;
        chk("R1 power-up restore midscale", wiper, WIPER_MID);

        do_read(0);
        do_sw_reset();
        do_write(10'h155);
        do_store();
        do_read(0);
        do_write(10'h2AA);

        // R5 R6: hardware pin rising edge, then held high
        hw_pin = 1;
        measure(len);
        m_wiper = exp_refresh();
        chk("R5 hw refresh busy length", len, TRS);
        chk("R5 hw refresh wiper", wiper, m_wiper);
        len = 0;
        for (int i = 0; i < 20; i++) begin
            if (busy) len++;
            @(negedge clk);
        end
        chk("R6 held pin no retrigger", len, 0);
        hw_pin = 0;
        @(negedge clk);

        // R8: commands during a store are dropped
        do_write(10'h0F0);
        c_st = 1; @(negedge clk); c_st = 0;
        c_wr = 1; c_data = 10'h3FF; c_sw = 1; c_rd = 1; hw_pin = 1;
        @(negedge clk);
        c_wr = 0; c_sw = 0; c_rd = 0;
        measure(len);
        m_mem[m_cnt] = m_wiper; m_cnt++;
        chk("R8 store length unaffected", len + 1, TST);
        repeat (3) @(negedge clk);
        chk("R8 busy stays low after lost edge", busy, 0);
        chk("R8 wiper unchanged", wiper, m_wiper);
        chk("R8 rd_valid not raised", rd_valid, 0);
        hw_pin = 0;
        do_read(1);

        // R9: priority collisions
        c_st = 1; c_wr = 1; c_data = 10'h001; @(negedge clk); c_st = 0; c_wr = 0;
        measure(len);
        m_mem[m_cnt] = m_wiper; m_cnt++;
        chk("R9 store beats write length", len, TST);
        chk("R9 store beats write wiper", wiper, m_wiper);
        held = m_wiper;
        do_write(10'h077);
        c_sw = 1; c_st = 1; @(negedge clk); c_sw = 0; c_st = 0;
        measure(len);
        m_wiper = exp_refresh();
        chk("R9 sw reset beats store length", len, TRS);
        chk("R9 sw reset beats store wiper", wiper, held);
        do_read(3);
        c_rd = 1; c_wr = 1; c_data = 10'h002; @(negedge clk); c_rd = 0; c_wr = 0;
        measure(len);
        chk("R9 read beats write length", len, TRD);
        chk("R9 read beats write data", rd_data, exp_read(2));
        chk("R9 read beats write wiper", wiper, m_wiper);

        // random mix
        for (int it = 0; it < 70; it++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 4)      do_write(WIPER_W'($urandom));
            else if (k < 6) do_store();
            else if (k < 8) do_read($urandom_range(0, 31));
            else            do_sw_reset();
        end

        // R4: fill memory, then reject
        while (m_cnt < SLOTS) begin
            do_write(WIPER_W'($urandom));
            do_store();
        end
        do_write(10'h123);
        do_store();
        do_read(SLOTS - 1);
        do_sw_reset();
        chk("R4 restore from last slot", wiper, m_mem[SLOTS-1]);
        do_read(25);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule